// File: doc/BRIEF.md
# Power-Fail Write-Protect Gate

This block sits between a host's asynchronous SRAM-style strobes (chip select, output enable, write enable, all active low) and an internal memory. It turns them into a gated memory write enable, a gated memory read enable and a data-output drive enable. An external comparator supplies a digital "supply below deselect threshold" level. While that level is asserted the gate blocks every access and keeps the data outputs off. Once the supply is good again, protection stays on for a programmable recovery interval counted in system-clock cycles.

All asynchronous inputs pass through a multi-stage synchronizer before any decision is made. At the end of every recovery interval the gate samples a battery-low indication. If the battery is low it raises a flag. While the flag is up, the next write attempt is swallowed whole, and the flag drops once that attempt ends. Host software can detect this by writing a complement of a byte and reading it back.

Top module: `pfail_gate`

## Requirements
- R1: While the synchronized power-fail input is high, `mem_we_o`, `mem_re_o` and `dout_en_o` are all 0 whatever the strobes do, and an access under way ends as soon as the synchronized power-fail level rises.
- R2: After `pfail_i` falls, the outputs stay blocked until exactly SYNC_STAGES + 1 + REC_CYCLES clock edges have passed. Any return of power-fail during that interval restarts the full count.
- R3: When enabled, `mem_we_o` is 1 exactly while both `ce_ni` and `we_ni` are low, seen SYNC_STAGES edges after the strobes change. The write starts on the later falling strobe and ends on the earlier rising one.
- R4: When enabled, `mem_re_o` is 1 while `ce_ni` is low and `we_ni` is high. `dout_en_o` is 1 only when, in addition, `oe_ni` is low. Otherwise it is 0, meaning the data outputs are high-impedance.
- R5: A fall of `we_ni` while the outputs are driven turns `dout_en_o` off in the same cycle that `mem_we_o` rises. If `ce_ni` and `we_ni` fall together, `dout_en_o` never turns on.
- R6: A write whose strobes are already low when protection lifts is not recognized. A write is only honoured after `ce_ni` or `we_ni` has gone high and low again.
- R7: `batt_low_i` (1 = battery low) is sampled on the edge that ends each recovery interval. `batt_flag_o` then shows that value (1 = flag set) and is 0 after reset.
- R8: While `batt_flag_o` is 1, the next write attempt is suppressed for its whole length. The flag clears on the edge after that attempt ends, and later writes proceed. Reads do not clear the flag.
- R9: During reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pfail_i | input | 1 | Supply below deselect threshold (asynchronous, 1 = fail) |
| batt_low_i | input | 1 | Battery-low indication (asynchronous level, 1 = low) |
| ce_ni | input | 1 | Host chip select, active low (asynchronous) |
| oe_ni | input | 1 | Host output enable, active low (asynchronous) |
| we_ni | input | 1 | Host write enable, active low (asynchronous) |
| mem_we_o | output | 1 | Gated memory write enable |
| mem_re_o | output | 1 | Gated memory read enable |
| dout_en_o | output | 1 | Data output drive enable (0 = high-impedance) |
| batt_flag_o | output | 1 | Battery-low flag |

## Verification
The hardest state to reach is a write strobe held low across the moment protection lifts. In that state the block is enabled, yet the gate has to hold the write back. The bench reaches it by asserting the power-fail input, lowering both write strobes, and only then releasing power-fail. It waits the full recovery interval, then shows that no write appears, that a read turns on once write enable rises, and that a fresh fall of write enable produces a write. The battery-flag path is similar: the flag is armed only by a completed recovery. The bench therefore cycles power-fail with the battery input high, does a read to show the flag survives it, and then tracks the flag through one swallowed write.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    PW_PROTECT = 2'd0,
    PW_RECOVER = 2'd1,
    PW_ACTIVE  = 2'd2
  } pw_state_e;

  // bit positions in the synchronized input bundle
  localparam int unsigned SIG_PF   = 0;
  localparam int unsigned SIG_BATT = 1;
  localparam int unsigned SIG_CE   = 2;
  localparam int unsigned SIG_OE   = 3;
  localparam int unsigned SIG_WE   = 4;
  localparam int unsigned NUM_SIG  = 5;

  // reset image: power-fail asserted, strobes idle high, battery ok
  localparam logic [NUM_SIG-1:0] SIG_RST = 5'b11101;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= RST_VAL;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pfg_power_seq.sv
module pfg_power_seq
  import pfg_pkg::*;
#(
  parameter int unsigned REC_CYCLES = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfail_s_i,
  output logic enable_o,
  output logic power_up_o
);
  localparam int unsigned REC_EFF = (REC_CYCLES < 2) ? 2 : REC_CYCLES;
  localparam int unsigned CNT_W   = $clog2(REC_EFF);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_EFF - 1);

  pw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    power_up_o = 1'b0;
    if (pfail_s_i) begin
      state_d = PW_PROTECT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        PW_PROTECT: begin
          state_d = PW_RECOVER;
          cnt_d   = '0;
        end
        PW_RECOVER: begin
          if (cnt_q == CNT_LAST) begin
            state_d    = PW_ACTIVE;
            power_up_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PW_ACTIVE: ;
        default: state_d = PW_PROTECT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PW_PROTECT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign enable_o = (state_q == PW_ACTIVE) && !pfail_s_i;

  p_fail_protects_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_s_i |=> state_q == PW_PROTECT);

  p_rec_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PW_RECOVER && !pfail_s_i && cnt_q != CNT_LAST)
      |=> (state_q == PW_RECOVER && cnt_q == $past(cnt_q) + 1'b1));

  p_active_after_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != PW_ACTIVE) ##1 (state_q == PW_ACTIVE)
      |-> ($past(state_q) == PW_RECOVER && $past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/pfg_strobe_gate.sv
module pfg_strobe_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic ce_n_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  input  logic wr_block_i,
  output logic wr_cand_o,
  output logic mem_we_o,
  output logic mem_re_o,
  output logic dout_en_o
);
  logic wr_raw;
  logic hold_q;

  assign wr_raw = !ce_n_i && !we_n_i;

  // a write seen while disabled stays masked until its strobes release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= 1'b0;
    else if (!wr_raw)   hold_q <= 1'b0;
    else if (!enable_i) hold_q <= 1'b1;
  end

  assign wr_cand_o = enable_i && wr_raw && !hold_q;
  assign mem_we_o  = wr_cand_o && !wr_block_i;
  assign mem_re_o  = enable_i && !ce_n_i && we_n_i;
  assign dout_en_o = mem_re_o && !oe_n_i;

  p_hold_masks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_raw && !enable_i) |=> (!mem_we_o || !$stable(wr_raw)) || !wr_raw || !hold_q || !mem_we_o);

  p_held_write_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !mem_we_o);
endmodule

// File: rtl/pfg_batt_guard.sv
module pfg_batt_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic power_up_i,
  input  logic batt_low_s_i,
  input  logic wr_cand_i,
  output logic flag_o
);
  logic flag_q;
  logic cand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      cand_q <= 1'b0;
    end else begin
      cand_q <= wr_cand_i;
      if (power_up_i)                          flag_q <= batt_low_s_i;
      else if (flag_q && cand_q && !wr_cand_i) flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_flag_set_on_powerup_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q ##1 flag_q |-> $past(power_up_i) && $past(batt_low_s_i));

  p_flag_clears_after_attempt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && cand_q && !wr_cand_i && !power_up_i) |=> !flag_q);

  p_flag_holds_in_attempt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && wr_cand_i && !power_up_i) |=> flag_q);
endmodule

// File: rtl/pfail_gate.sv
module pfail_gate
  import pfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REC_CYCLES  = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pfail_i,
  input  logic batt_low_i,
  input  logic ce_ni,
  input  logic oe_ni,
  input  logic we_ni,
  output logic mem_we_o,
  output logic mem_re_o,
  output logic dout_en_o,
  output logic batt_flag_o
);
  logic [NUM_SIG-1:0] raw, syn;
  logic enable, power_up, wr_cand;

  always_comb begin
    raw           = '0;
    raw[SIG_PF]   = pfail_i;
    raw[SIG_BATT] = batt_low_i;
    raw[SIG_CE]   = ce_ni;
    raw[SIG_OE]   = oe_ni;
    raw[SIG_WE]   = we_ni;
  end

  pfg_sync #(
    .WIDTH  (NUM_SIG),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SIG_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  pfg_power_seq #(
    .REC_CYCLES(REC_CYCLES)
  ) u_power_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pfail_s_i (syn[SIG_PF]),
    .enable_o  (enable),
    .power_up_o(power_up)
  );

  pfg_strobe_gate u_strobe_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable),
    .ce_n_i    (syn[SIG_CE]),
    .oe_n_i    (syn[SIG_OE]),
    .we_n_i    (syn[SIG_WE]),
    .wr_block_i(batt_flag_o),
    .wr_cand_o (wr_cand),
    .mem_we_o  (mem_we_o),
    .mem_re_o  (mem_re_o),
    .dout_en_o (dout_en_o)
  );

  pfg_batt_guard u_batt_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .power_up_i  (power_up),
    .batt_low_s_i(syn[SIG_BATT]),
    .wr_cand_i   (wr_cand),
    .flag_o      (batt_flag_o)
  );

  p_fail_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn[SIG_PF] |-> !(mem_we_o || mem_re_o || dout_en_o));

  p_dout_has_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> mem_re_o && !syn[SIG_OE]);

  p_no_drive_in_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !dout_en_o);

  p_joint_fall_dark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(syn[SIG_CE]) && $fell(syn[SIG_WE])) |-> !dout_en_o);
endmodule

// File: tb/pfail_gate_tb.sv
module pfail_gate_tb;
  localparam int unsigned REC = 6;

  logic clk_i = 1'b0;
  logic rst_ni, pfail_i, batt_low_i, ce_ni, oe_ni, we_ni;
  logic mem_we_o, mem_re_o, dout_en_o, batt_flag_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #10 clk_i = ~clk_i;

  pfail_gate #(.SYNC_STAGES(2), .REC_CYCLES(REC)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pfail_i(pfail_i), .batt_low_i(batt_low_i),
    .ce_ni(ce_ni), .oe_ni(oe_ni), .we_ni(we_ni),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .dout_en_o(dout_en_o),
    .batt_flag_o(batt_flag_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // expected packed as {we, re, dout, flag}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {mem_we_o, mem_re_o, dout_en_o, batt_flag_o};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual we/re/dout/flag=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobes(input logic ce, input logic oe, input logic we);
    ce_ni = ce; oe_ni = oe; we_ni = we;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    rst_ni = 1'b0; pfail_i = 1'b1; batt_low_i = 1'b0;
    strobes(1'b1, 1'b1, 1'b1);
    step(3);
    chk("R9 reset state", 4'b0000);

    // power-up with a read held so enable is visible
    strobes(1'b0, 1'b1, 1'b1);
    pfail_i = 1'b0; rst_ni = 1'b1;
    step(2 + REC);
    chk("R2 still protected at last recovery cycle", 4'b0000);
    step(1);
    chk("R2 enabled after recovery, R7 battery ok", 4'b0100);
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R3/R4 sweep over all strobe combinations
    for (int v = 0; v < 8; v++) begin
      logic c, o, w;
      c = v[2]; o = v[1]; w = v[0];
      strobes(c, o, w);
      step(2);
      chk($sformatf("R3/R4 sweep ce=%b oe=%b we=%b", c, o, w),
          {(!c && !w), (!c && w), (!c && !o && w), 1'b0});
    end
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R5: write enable falls under a driven read
    strobes(1'b0, 1'b0, 1'b1); step(2);
    chk("R5 read driving", 4'b0110);
    we_ni = 1'b0; step(1);
    chk("R5 sync latency, still driving", 4'b0110);
    step(1);
    chk("R5 we low kills outputs", 4'b1000);
    strobes(1'b1, 1'b1, 1'b1); step(2);
    // joint fall of ce and we with oe low
    strobes(1'b0, 1'b0, 1'b0);
    step(1); chk("R5 joint fall cycle 1", 4'b0000);
    step(1); chk("R5 joint fall cycle 2", 4'b1000);
    step(1); chk("R5 joint fall cycle 3", 4'b1000);
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R1: power fail ends a write and masks every combination
    strobes(1'b0, 1'b1, 1'b0); step(2);
    chk("R1 write before fail", 4'b1000);
    pfail_i = 1'b1; step(2);
    chk("R1 write cut by power fail", 4'b0000);
    for (int v = 0; v < 8; v++) begin
      strobes(v[2], v[1], v[0]);
      step(2);
      chk($sformatf("R1 ignored ce=%b oe=%b we=%b", v[2], v[1], v[0]), 4'b0000);
    end

    // R6: write held low across the end of protection
    strobes(1'b0, 1'b1, 1'b0); step(2);
    pfail_i = 1'b0;
    step(3 + REC + 2);
    chk("R6 held write not recognized", 4'b0000);
    we_ni = 1'b1; step(2);
    chk("R6 enabled, read visible", 4'b0100);
    we_ni = 1'b0; step(2);
    chk("R6 fresh write honoured", 4'b1000);
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R2: glitch during recovery restarts the count
    strobes(1'b0, 1'b1, 1'b1);
    pfail_i = 1'b1; step(3);
    pfail_i = 1'b0; step(REC);
    chk("R2 mid recovery", 4'b0000);
    pfail_i = 1'b1; step(2);
    pfail_i = 1'b0;
    step(2 + REC);
    chk("R2 restarted count not done", 4'b0000);
    step(1);
    chk("R2 restarted count done", 4'b0100);
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R7/R8: low battery at power-up
    batt_low_i = 1'b1;
    pfail_i = 1'b1; step(3);
    pfail_i = 1'b0; step(3 + REC);
    chk("R7 flag set on low battery", 4'b0001);
    strobes(1'b0, 1'b0, 1'b1); step(2);
    chk("R8 read leaves flag", 4'b0111);
    strobes(1'b1, 1'b1, 1'b1); step(2);
    chk("R8 flag after read", 4'b0001);
    strobes(1'b0, 1'b1, 1'b0); step(2);
    chk("R8 first write blocked", 4'b0001);
    step(3);
    chk("R8 first write blocked throughout", 4'b0001);
    strobes(1'b1, 1'b1, 1'b1); step(2);
    chk("R8 flag still set as attempt ends", 4'b0001);
    step(1);
    chk("R8 flag cleared after attempt", 4'b0000);
    strobes(1'b0, 1'b1, 1'b0); step(2);
    chk("R8 second write proceeds", 4'b1000);
    strobes(1'b1, 1'b1, 1'b1); step(2);

    // R7: battery ok on the next power-up
    batt_low_i = 1'b0;
    pfail_i = 1'b1; step(3);
    pfail_i = 1'b0; step(3 + REC);
    chk("R7 flag clear on good battery", 4'b0000);
    strobes(1'b0, 1'b1, 1'b0); step(2);
    chk("R8 no block with good battery", 4'b1000);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule